// File: doc/BRIEF.md
# ADC Multi-Mode Scan Sequencer

This block decides which analog input a four-input converter samples next and when it does so. It also files each 8-bit result into one of four result registers. A start condition begins a run. The start comes from a software pulse, a timer overflow, or a chosen edge on an external pin. Once started, the block issues conversion requests to the converter engine over a start/done handshake, and the engine returns a data byte with its done strobe.

Six operating modes control three things: which channel is converted, which result register receives the result, and which completions raise the interrupt. Continuous modes run until a stop request, and the conversion in flight always completes before the block returns to idle. Mode, channel mask and channel choices are captured when a run starts. Start conditions that arrive while a conversion is in progress are ignored.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy_o`, `irq_o` and `conv_start_o` are 0 and every result register in `res_o` reads 0.
- R2: Mode 0 (one-shot fixed) converts channel `cha_i` once. The result goes to register `cha_i`, one interrupt follows, and the block returns to idle.
- R3: Mode 1 (looping fixed) converts channel `cha_i` repeatedly. Results go to registers 0, 1, 2, 3 in rotation, and an interrupt follows every fourth conversion.
- R4: Mode 2 (one-shot scan) converts each channel whose `ch_mask_i` bit is 1, once each, in ascending channel order. Each result goes to its own channel's register, and one interrupt follows the highest selected channel. With an all-zero mask, a start condition starts nothing.
- R5: Mode 3 (looping scan) repeats the mode 2 scan and wraps back to the lowest selected channel after each pass. An interrupt follows each pass.
- R6: Mode 4 (paired) converts `cha_i`, `chb_i`, `cha_i`, `chb_i` into registers 0, 1, 2, 3 and repeats. An interrupt follows each group of four.
- R7: Mode 5 (stepped) performs one conversion per start condition, visiting the selected channels in ascending order with wrap. Each result goes to its channel's register, and each conversion raises an interrupt.
- R8: `stop_i`, given during a run, lets the conversion in flight finish. The block then goes idle and issues no further `conv_start_o`. Modes 6 and 7 never start.
- R9: `src_i` selects the start source: 0 `sw_start_i`, 1 `tmr_ovf_i`, 2 pin edge, 3 none. Events on sources that are not selected have no effect.
- R10: `pin_i` passes through two synchronizer flops and then an edge detector. `edge_pol_i` = 1 selects rising edges and 0 selects falling edges. `busy_o` rises on the third rising clock edge after the pin changes.
- R11: Start conditions that arrive between a conversion request and its done strobe are ignored.
- R12: An accepted start raises `busy_o` and a one-cycle `conv_start_o` on the next clock edge. `conv_ch_o` holds its value until done. `irq_o` is a one-cycle pulse on the edge that samples the interrupting `conv_done_i`. A result is written to `res_o[k*8 +: 8]` for register k on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode, 0 to 5 |
| src_i | input | 2 | Start source select |
| sw_start_i | input | 1 | Software start pulse |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| pin_i | input | 1 | Asynchronous trigger pin |
| edge_pol_i | input | 1 | 1 rising, 0 falling edge on pin |
| ch_mask_i | input | 4 | Channel select mask for scan and stepped modes |
| cha_i | input | 2 | Fixed channel, first channel of the pair |
| chb_i | input | 2 | Second channel of the pair |
| stop_i | input | 1 | Stop request for the current run |
| conv_start_o | output | 1 | Conversion request pulse to the engine |
| conv_ch_o | output | 2 | Channel to convert |
| conv_done_i | input | 1 | Engine done strobe |
| conv_data_i | input | 8 | Engine result |
| res_o | output | 32 | Four result registers, register k at bits k*8+7:k*8 |
| irq_o | output | 1 | Interrupt pulse |
| busy_o | output | 1 | Run in progress |

## Verification
A start accepted at one clock edge shows as `busy_o` and `conv_start_o` at the next sample point, and `conv_start_o` must be low one cycle later. A pin edge needs three edges before `busy_o` reads 1. The bench therefore counts negative edges from the moment it drives the pin and checks busy after the first, second and third. The bench's engine model returns done three cycles after each request, with data that encodes the channel and the conversion's index. Interrupts are logged against the number of done strobes already given, so each interrupt is matched to the conversion that caused it. Result registers, channel order and interrupt positions are compared only after `busy_o` has fallen and a few idle cycles have passed. Those idle cycles also show that no request follows a stop.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        M_FIX_ONE   = 3'd0,
        M_FIX_LOOP  = 3'd1,
        M_SCAN_ONE  = 3'd2,
        M_SCAN_LOOP = 3'd3,
        M_PAIR      = 3'd4,
        M_STEP      = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_PAUSE = 2'd3
    } state_e;

    // modes whose channel walk follows the mask
    function automatic logic uses_mask(input mode_e m);
        return (m == M_SCAN_ONE) || (m == M_SCAN_LOOP) || (m == M_STEP);
    endfunction

    // modes that fill registers by rotating slot
    function automatic logic uses_slot(input mode_e m);
        return (m == M_FIX_LOOP) || (m == M_PAIR);
    endfunction

endpackage

// File: rtl/adc_trig_unit.sv
module adc_trig_unit
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_i,
    input  logic       sw_start_i,
    input  logic       tmr_ovf_i,
    input  logic       pin_i,
    input  logic       edge_pol_i,
    output logic       trig_o
);
    localparam int SYNC_LEN = 2;

    logic [SYNC_LEN-1:0] sync_q;
    logic                hist_q;
    logic                pin_s;
    logic                pin_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], pin_i};
            hist_q <= sync_q[SYNC_LEN-1];
        end
    end

    assign pin_s   = sync_q[SYNC_LEN-1];
    assign pin_evt = edge_pol_i ? (pin_s & ~hist_q) : (~pin_s & hist_q);

    always_comb begin
        case (src_e'(src_i))
            SRC_SW:  trig_o = sw_start_i;
            SRC_TMR: trig_o = tmr_ovf_i;
            SRC_PIN: trig_o = pin_evt;
            default: trig_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [CW-1:0]     idx_i,
    input  logic [DW-1:0]     data_i,
    output logic [NCH*DW-1:0] res_o
);
    for (genvar k = 0; k < NCH; k++) begin : g_reg
        logic [DW-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (wr_i && (idx_i == CW'(k)))
                val_q <= data_i;
        end
        assign res_o[k*DW +: DW] = val_q;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trig_i,
    input  logic           stop_i,
    input  logic [2:0]     mode_i,
    input  logic [NCH-1:0] mask_i,
    input  logic [CW-1:0]  cha_i,
    input  logic [CW-1:0]  chb_i,
    input  logic           done_i,
    output logic           start_o,
    output logic [CW-1:0]  ch_o,
    output logic           wr_o,
    output logic [CW-1:0]  wr_idx_o,
    output logic           irq_o,
    output logic           busy_o
);
    localparam logic [CW-1:0] LAST_SLOT = CW'(NCH - 1);

    function automatic logic [CW-1:0] lowest_sel(input logic [NCH-1:0] m);
        logic [CW-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (m[i]) r = CW'(i);
        return r;
    endfunction

    function automatic logic sel_above(input logic [NCH-1:0] m, input logic [CW-1:0] cur);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NCH; i++)
            if (m[i] && (i > int'(cur))) r = 1'b1;
        return r;
    endfunction

    function automatic logic [CW-1:0] next_sel(input logic [NCH-1:0] m, input logic [CW-1:0] cur);
        logic [CW-1:0] r;
        r = lowest_sel(m);
        for (int i = NCH - 1; i >= 0; i--)
            if (m[i] && (i > int'(cur))) r = CW'(i);
        return r;
    endfunction

    state_e         st_q, st_n;
    mode_e          mode_q, mode_n, mode_in;
    logic [NCH-1:0] mask_q, mask_n;
    logic [CW-1:0]  cha_q, cha_n, chb_q, chb_n;
    logic [CW-1:0]  ch_q, ch_n;
    logic [CW-1:0]  slot_q, slot_n;
    logic           stop_q;
    logic           irq_q, irq_n;
    logic           start_ok;
    logic           halt;
    logic           pass_end;
    logic           slot_wrap;

    assign mode_in   = mode_e'(mode_i);
    assign halt      = stop_q | stop_i;
    assign pass_end  = ~sel_above(mask_q, ch_q);
    assign slot_wrap = (slot_q == LAST_SLOT);

    always_comb begin
        case (mode_in)
            M_FIX_ONE, M_FIX_LOOP, M_PAIR:  start_ok = 1'b1;
            M_SCAN_ONE, M_SCAN_LOOP, M_STEP: start_ok = |mask_i;
            default:                         start_ok = 1'b0;
        endcase
    end

    always_comb begin
        st_n     = st_q;
        mode_n   = mode_q;
        mask_n   = mask_q;
        cha_n    = cha_q;
        chb_n    = chb_q;
        ch_n     = ch_q;
        slot_n   = slot_q;
        irq_n    = 1'b0;
        wr_o     = 1'b0;
        wr_idx_o = uses_slot(mode_q) ? slot_q : ch_q;
        case (st_q)
            ST_IDLE: begin
                if (trig_i && start_ok) begin
                    st_n   = ST_ISSUE;
                    mode_n = mode_in;
                    mask_n = mask_i;
                    cha_n  = cha_i;
                    chb_n  = chb_i;
                    slot_n = '0;
                    ch_n   = uses_mask(mode_in) ? lowest_sel(mask_i) : cha_i;
                end
            end
            ST_ISSUE: st_n = ST_WAIT;
            ST_WAIT: begin
                if (done_i) begin
                    wr_o   = 1'b1;
                    slot_n = slot_wrap ? '0 : slot_q + 1'b1;
                    case (mode_q)
                        M_FIX_ONE: begin
                            irq_n = 1'b1;
                            st_n  = ST_IDLE;
                        end
                        M_FIX_LOOP: begin
                            irq_n = slot_wrap;
                            st_n  = halt ? ST_IDLE : ST_ISSUE;
                        end
                        M_SCAN_ONE: begin
                            irq_n = pass_end;
                            ch_n  = next_sel(mask_q, ch_q);
                            st_n  = (pass_end || halt) ? ST_IDLE : ST_ISSUE;
                        end
                        M_SCAN_LOOP: begin
                            irq_n = pass_end;
                            ch_n  = next_sel(mask_q, ch_q);
                            st_n  = halt ? ST_IDLE : ST_ISSUE;
                        end
                        M_PAIR: begin
                            irq_n = slot_wrap;
                            ch_n  = slot_q[0] ? cha_q : chb_q;
                            st_n  = halt ? ST_IDLE : ST_ISSUE;
                        end
                        M_STEP: begin
                            irq_n = 1'b1;
                            ch_n  = next_sel(mask_q, ch_q);
                            st_n  = halt ? ST_IDLE : ST_PAUSE;
                        end
                        default: st_n = ST_IDLE;
                    endcase
                end
            end
            ST_PAUSE: begin
                if (stop_i)
                    st_n = ST_IDLE;
                else if (trig_i)
                    st_n = ST_ISSUE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= M_FIX_ONE;
            mask_q <= '0;
            cha_q  <= '0;
            chb_q  <= '0;
            ch_q   <= '0;
            slot_q <= '0;
            irq_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            mode_q <= mode_n;
            mask_q <= mask_n;
            cha_q  <= cha_n;
            chb_q  <= chb_n;
            ch_q   <= ch_n;
            slot_q <= slot_n;
            irq_q  <= irq_n;
            if (st_n == ST_IDLE)
                stop_q <= 1'b0;
            else if (stop_i)
                stop_q <= 1'b1;
        end
    end

    assign start_o = (st_q == ST_ISSUE);
    assign ch_o    = ch_q;
    assign irq_o   = irq_q;
    assign busy_o  = (st_q != ST_IDLE);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic [1:0]        src_i,
    input  logic              sw_start_i,
    input  logic              tmr_ovf_i,
    input  logic              pin_i,
    input  logic              edge_pol_i,
    input  logic [NCH-1:0]    ch_mask_i,
    input  logic [CW-1:0]     cha_i,
    input  logic [CW-1:0]     chb_i,
    input  logic              stop_i,
    output logic              conv_start_o,
    output logic [CW-1:0]     conv_ch_o,
    input  logic              conv_done_i,
    input  logic [DW-1:0]     conv_data_i,
    output logic [NCH*DW-1:0] res_o,
    output logic              irq_o,
    output logic              busy_o
);
    logic          trig;
    logic          wr;
    logic [CW-1:0] wr_idx;

    adc_trig_unit u_trig (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .sw_start_i (sw_start_i),
        .tmr_ovf_i  (tmr_ovf_i),
        .pin_i      (pin_i),
        .edge_pol_i (edge_pol_i),
        .trig_o     (trig)
    );

    adc_seq_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (trig),
        .stop_i   (stop_i),
        .mode_i   (mode_i),
        .mask_i   (ch_mask_i),
        .cha_i    (cha_i),
        .chb_i    (chb_i),
        .done_i   (conv_done_i),
        .start_o  (conv_start_o),
        .ch_o     (conv_ch_o),
        .wr_o     (wr),
        .wr_idx_o (wr_idx),
        .irq_o    (irq_o),
        .busy_o   (busy_o)
    );

    adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .idx_i  (wr_idx),
        .data_i (conv_data_i),
        .res_o  (res_o)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_i,
    input logic              conv_start_o,
    input logic [CW-1:0]     conv_ch_o,
    input logic              conv_done_i,
    input logic [NCH*DW-1:0] res_o,
    input logic              irq_o,
    input logic              busy_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy_o && !irq_o && !conv_start_o && (res_o == '0)))
        else $error("reset state wrong"); // R1

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o)
        else $error("conversion request longer than one cycle"); // R12

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> busy_o)
        else $error("request while idle"); // R12

    AST_CH_HELD: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> $stable(conv_ch_o))
        else $error("channel changed during conversion"); // R12

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o)
        else $error("interrupt longer than one cycle"); // R12

    AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(conv_done_i))
        else $error("interrupt without done"); // R12

    AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (stop_i && conv_done_i && busy_o && !conv_start_o) |=> !busy_o)
        else $error("run continued after stop"); // R8

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .stop_i       (stop_i),
    .conv_start_o (conv_start_o),
    .conv_ch_o    (conv_ch_o),
    .conv_done_i  (conv_done_i),
    .res_o        (res_o),
    .irq_o        (irq_o),
    .busy_o       (busy_o)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = '0;
    logic [1:0]  src_i = '0;
    logic        sw_start_i = 1'b0;
    logic        tmr_ovf_i = 1'b0;
    logic        pin_i = 1'b0;
    logic        edge_pol_i = 1'b1;
    logic [3:0]  ch_mask_i = '0;
    logic [1:0]  cha_i = '0;
    logic [1:0]  chb_i = '0;
    logic        stop_i = 1'b0;
    logic        conv_start_o;
    logic [1:0]  conv_ch_o;
    logic        conv_done_i = 1'b0;
    logic [7:0]  conv_data_i = '0;
    logic [31:0] res_o;
    logic        irq_o;
    logic        busy_o;

    adc_scan_seq u_adc_scan_seq (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int nst = 0;
    int ndone = 0;
    int nirq = 0;
    int pend = 0;
    logic [1:0] pend_ch = '0;
    int log_ch [0:63];
    int irq_at [0:63];
    int exp_res [0:3];
    int cm, cmask, ca, cb;

    // engine model and port monitor
    always @(negedge clk) begin
        if (irq_o) begin
            if (nirq < 64) irq_at[nirq] = ndone;
            nirq++;
        end
        conv_done_i = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                conv_done_i = 1'b1;
                conv_data_i = {pend_ch, 6'(ndone)};
                ndone++;
            end
        end
        if (conv_start_o) begin
            if (nst < 64) log_ch[nst] = int'(conv_ch_o);
            nst++;
            pend = LAT;
            pend_ch = conv_ch_o;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nsel();
        return $countones(4'(cmask));
    endfunction

    function automatic int kth_sel(input int k);
        int c = 0;
        for (int i = 0; i < 4; i++)
            if (cmask[i]) begin
                if (c == k) return i;
                c++;
            end
        return 0;
    endfunction

    function automatic int exp_ch(input int i);
        case (cm)
            0, 1: return ca;
            4: return (i % 2 == 1) ? cb : ca;
            default: return kth_sel(i % nsel());
        endcase
    endfunction

    function automatic int exp_reg(input int i);
        if (cm == 1 || cm == 4) return i % 4;
        return exp_ch(i);
    endfunction

    function automatic bit exp_irq(input int i);
        case (cm)
            0, 5: return 1'b1;
            1, 4: return (i % 4) == 3;
            default: return (i % nsel()) == nsel() - 1;
        endcase
    endfunction

    task automatic clear_log();
        @(negedge clk);
        nst = 0; ndone = 0; nirq = 0;
    endtask

    task automatic set_cfg(input int m, input int mask, input int a, input int b);
        cm = m; cmask = mask; ca = a; cb = b;
        @(negedge clk);
        mode_i = 3'(m); ch_mask_i = 4'(mask); cha_i = 2'(a); chb_i = 2'(b);
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_start_i = 1'b1;
        @(negedge clk) sw_start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic verify(input string req, input int n);
        int ei = 0;
        chk(req, "conversion count", nst, n);
        chk(req, "idle after run", int'(busy_o), 0);
        for (int i = 0; i < n && i < 64; i++) begin
            chk(req, $sformatf("channel of conversion %0d", i), log_ch[i], exp_ch(i));
            exp_res[exp_reg(i)] = exp_ch(i) * 64 + (i % 64);
            if (exp_irq(i)) begin
                if (ei < nirq && ei < 64)
                    chk(req, $sformatf("interrupt %0d position", ei), irq_at[ei], i + 1);
                ei++;
            end
        end
        chk(req, "interrupt count", nirq, ei);
        for (int r = 0; r < 4; r++)
            chk(req, $sformatf("result register %0d", r), int'(res_o[r*8 +: 8]), exp_res[r]);
    endtask

    task automatic run_loop(input string req, input int n);
        clear_log();
        pulse_sw();
        while (nst < n) @(negedge clk);
        pulse_stop();
        wait_idle();
        verify(req, n);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        for (int r = 0; r < 4; r++) exp_res[r] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "irq", int'(irq_o), 0);
        chk("R1", "conv_start", int'(conv_start_o), 0);
        chk("R1", "results", int'(res_o != 0), 0);

        // R2 one-shot fixed, every channel
        for (int c = 0; c < 4; c++) begin
            set_cfg(0, 0, c, 0);
            clear_log(); pulse_sw(); wait_idle();
            verify("R2", 1);
        end

        // R3 looping fixed with stop (R8)
        for (int c = 0; c < 4; c++) begin
            set_cfg(1, 0, c, 0);
            run_loop("R3_R8", 9);
        end

        // R4 one-shot scan over every mask
        for (int m = 0; m < 16; m++) begin
            set_cfg(2, m, 0, 0);
            clear_log(); pulse_sw(); wait_idle();
            verify("R4", $countones(4'(m)));
        end

        // R5 looping scan, wrap
        for (int k = 0; k < 4; k++) begin
            set_cfg(3, (k == 0) ? 5 : (k == 1) ? 11 : (k == 2) ? 15 : 8, 0, 0);
            run_loop("R5", 7);
        end

        // R6 paired mode, all channel pairs
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                set_cfg(4, 0, a, b);
                run_loop("R6", 8);
            end

        // R7 stepped mode
        for (int k = 0; k < 2; k++) begin
            set_cfg(5, (k == 0) ? 6 : 13, 0, 0);
            clear_log();
            for (int s = 0; s < 6; s++) begin
                pulse_sw();
                while (busy_o && nirq <= s) @(negedge clk);
                repeat (3) @(negedge clk);
                chk("R7", "paused between steps", int'(busy_o), 1);
                chk("R7", "one conversion per step", nst, s + 1);
            end
            pulse_stop();
            wait_idle();
            verify("R7", 6);
        end

        // R8 modes 6 and 7 never start
        for (int m = 6; m < 8; m++) begin
            @(negedge clk) mode_i = 3'(m);
            clear_log(); pulse_sw(); repeat (4) @(negedge clk);
            chk("R8", "reserved mode start count", nst, 0);
        end

        // R9 timer source: software pulse ignored, overflow starts
        set_cfg(0, 0, 2, 0);
        @(negedge clk) src_i = 2'd1;
        clear_log(); pulse_sw(); repeat (4) @(negedge clk);
        chk("R9", "software pulse with timer source", nst, 0);
        @(negedge clk) tmr_ovf_i = 1'b1;
        @(negedge clk) tmr_ovf_i = 1'b0;
        chk("R12", "busy after accepted start", int'(busy_o), 1);
        chk("R12", "request pulse", int'(conv_start_o), 1);
        @(negedge clk);
        chk("R12", "request pulse ended", int'(conv_start_o), 0);
        // R11 overflow while converting is ignored
        tmr_ovf_i = 1'b1;
        @(negedge clk) tmr_ovf_i = 1'b0;
        wait_idle();
        verify("R9_R11", 1);

        // R9 source 3 ignores everything
        @(negedge clk) src_i = 2'd3;
        clear_log();
        @(negedge clk) begin tmr_ovf_i = 1'b1; sw_start_i = 1'b1; end
        @(negedge clk) begin tmr_ovf_i = 1'b0; sw_start_i = 1'b0; end
        repeat (4) @(negedge clk);
        chk("R9", "no source selected", nst, 0);

        // R10 rising pin edge, latency of three edges
        set_cfg(0, 0, 1, 0);
        @(negedge clk) begin src_i = 2'd2; edge_pol_i = 1'b1; end
        clear_log();
        @(negedge clk) pin_i = 1'b1;
        @(negedge clk) chk("R10", "busy after one edge", int'(busy_o), 0);
        @(negedge clk) chk("R10", "busy after two edges", int'(busy_o), 0);
        @(negedge clk) chk("R10", "busy after three edges", int'(busy_o), 1);
        wait_idle();
        verify("R10", 1);

        // R10 falling polarity
        set_cfg(0, 0, 3, 0);
        @(negedge clk) edge_pol_i = 1'b0;
        clear_log();
        @(negedge clk) pin_i = 1'b0;
        @(negedge clk);
        @(negedge clk) chk("R10", "falling busy after two edges", int'(busy_o), 0);
        @(negedge clk) chk("R10", "falling busy after three edges", int'(busy_o), 1);
        wait_idle();
        verify("R10", 1);
        clear_log();
        @(negedge clk) pin_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", "rising edge ignored with falling polarity", nst, 0);

        finish_run();
    end

endmodule